// File: doc/BRIEF.md
# Triggered Multi-Channel Pulse Generator

The block holds eight one-shot pulse generators that share a single start input. A serial slave port loads all eight 12-bit widths in one 96-bit frame. The frame is committed to the width registers only when select goes high again. A rising edge on the start input sets every channel with a nonzero width high in the same cycle. Each channel then goes low when a shared counter reaches that channel's width. A width of 0 gives no pulse. The largest width, 4095, ends within 2^12 clock cycles of the start.

The same serial port also reads results back. When select falls, eight 12-bit measured durations are captured from a parallel input, which another block supplies. They are shifted out on MISO while the frame is clocked in. All serial pins and the start input are synchronised to the system clock. The serial clock must therefore be much slower than the system clock.

Top module: `trig_pulse_bank`

## Requirements
- R1: After reset, `pulse_out` is all zero, `spi_miso` is 0 and every width register holds 0. A start edge before any frame is committed therefore produces no pulse.
- R2: A frame of exactly 96 bits, sampled on rising `spi_sclk` while `spi_cs_n` is low, is committed when `spi_cs_n` rises. Channel 0 is the first 12 bits shifted, then channels 1 to 7 follow, and each field is sent MSB first.
- R3: A frame with any bit count other than 96 leaves all width registers unchanged.
- R4: A rising edge on `trig_in`, after synchronisation, drives every channel with a nonzero width high in the same clock cycle.
- R5: A channel with width w (1 to 4095) stays high for exactly w system clock cycles.
- R6: A channel with width 0 stays low through the whole run.
- R7: A width of 4095 gives a pulse of 4095 cycles, so every pulse ends within 2^12 cycles of the start.
- R8: A new start edge during a run restarts the count. A channel that is still high stays high without a gap and ends w cycles after the second start. A channel that has already ended fires again.
- R9: Widths committed during a run do not change that run. They take effect on the next start edge.
- R10: When `spi_cs_n` falls, `dur_in` is captured, with channel i at bits [12i+11:12i]. The captured values are shifted out on `spi_miso` as channel 0 first, each field MSB first. A new bit is presented after each falling `spi_sclk` and is valid at the next rising edge.
- R11: `spi_miso` is 0 while `spi_cs_n` is high.
- R12: Holding `trig_in` high starts only one run. Only a low-to-high transition starts a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, asynchronous to clk |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_mosi | input | 1 | Serial data in (widths) |
| spi_miso | output | 1 | Serial data out (durations), registered |
| trig_in | input | 1 | Common start, rising edge active |
| dur_in | input | 96 | Measured durations, channel i at [12i+11:12i] |
| pulse_out | output | 8 | Pulse outputs, registered |

## Verification
The bench drives frames with mixed widths and checks four edge values in turn. Width 0 tests for a comparator that matches on an idle counter and gives a stray pulse. Width 1 and width 4095 test for an off-by-one error at either end of the count. A short frame tests for a commit made without checking the bit count, which would load a shifted, corrupted set of widths. A start edge in the middle of a pulse exposes a design that lets the output drop for a cycle or that fails to restart channels that have already ended. A frame committed during a long run catches a design that compares against live widths and cuts the pulse short. Holding the start input high catches a level-sensitive start that would fire again and again.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  localparam int unsigned DEF_NCH = 8;
  localparam int unsigned DEF_WW  = 12;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_t;

  function automatic int unsigned frame_bits(input int unsigned nch, input int unsigned ww);
    return nch * ww;
  endfunction
endpackage

// File: rtl/tpb_sync.sv
module tpb_sync #(
  parameter int unsigned N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q_out
);
  logic [N-1:0] meta_q;
  logic [N-1:0] stab_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= RST_VAL[i];
        stab_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_in[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign q_out = stab_q;
endmodule

// File: rtl/tpb_edge.sv
module tpb_edge #(
  parameter int unsigned N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = lvl[i] & ~prev_q[i];
    assign fall[i] = ~lvl[i] & prev_q[i];
  end
endmodule

// File: rtl/tpb_spi_port.sv
module tpb_spi_port #(
  parameter int unsigned NCH = 8,
  parameter int unsigned WW  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sel_lvl_n,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              mosi_lvl,
  input  logic [NCH*WW-1:0] dur_flat,
  output logic [NCH*WW-1:0] width_flat,
  output logic              commit,
  output logic              miso
);
  localparam int unsigned TOT = tpb_pkg::frame_bits(NCH, WW);
  localparam int unsigned CW  = $clog2(TOT + 2);
  localparam logic [CW-1:0] FULL = CW'(TOT);

  logic [TOT-1:0] rx_sh_q;
  logic [TOT-1:0] frame_q;
  logic [TOT-1:0] tx_sh_q;
  logic [TOT-1:0] dur_frame;
  logic [CW-1:0]  bit_cnt_q;
  logic           commit_q;
  logic           miso_q;
  logic           sel_act;

  assign sel_act = ~sel_lvl_n;

  // Frame order: channel 0 in the top field, the first one on the wire.
  for (genvar i = 0; i < NCH; i++) begin : g_map
    assign width_flat[i*WW +: WW]          = frame_q[TOT-1-i*WW -: WW];
    assign dur_frame[TOT-1-i*WW -: WW]     = dur_flat[i*WW +: WW];
  end

  // Receive shifter and bit count.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh_q   <= '0;
      bit_cnt_q <= '0;
    end else if (sel_fall) begin
      bit_cnt_q <= '0;
    end else if (sel_act && sclk_rise) begin
      rx_sh_q <= {rx_sh_q[TOT-2:0], mosi_lvl};
      if (bit_cnt_q != '1) bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  // Commit only a complete frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q  <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (sel_rise && bit_cnt_q == FULL) begin
        frame_q  <= rx_sh_q;
        commit_q <= 1'b1;
      end
    end
  end

  // Transmit shifter: loaded at select fall, advanced on sclk fall.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh_q <= '0;
    end else if (sel_fall) begin
      tx_sh_q <= dur_frame;
    end else if (sel_act && sclk_fall) begin
      tx_sh_q <= {tx_sh_q[TOT-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) miso_q <= 1'b0;
    else     miso_q <= sel_act & tx_sh_q[TOT-1];
  end

  assign commit = commit_q;
  assign miso   = miso_q;
endmodule

// File: rtl/tpb_pulse_engine.sv
module tpb_pulse_engine #(
  parameter int unsigned NCH = 8,
  parameter int unsigned WW  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_lvl,
  input  logic [NCH*WW-1:0] width_flat,
  output logic [NCH-1:0]    pulse,
  output logic              start,
  output logic [WW-1:0]     cnt,
  output logic [NCH*WW-1:0] act_flat
);
  localparam logic [WW-1:0] CNT_LAST = '1;

  tpb_pkg::eng_state_t state_q;
  logic                trig_prev_q;
  logic [WW-1:0]       cnt_q;
  logic [NCH*WW-1:0]   act_q;
  logic [NCH-1:0]      pulse_q;
  logic [NCH-1:0]      hit;

  assign start = trig_lvl & ~trig_prev_q;

  always_ff @(posedge clk) begin
    if (rst) trig_prev_q <= 1'b1;
    else     trig_prev_q <= trig_lvl;
  end

  // Shared counter; widths snapshot at start.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= tpb_pkg::ENG_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
    end else if (start) begin
      state_q <= tpb_pkg::ENG_RUN;
      cnt_q   <= WW'(1);
      act_q   <= width_flat;
    end else if (state_q == tpb_pkg::ENG_RUN) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) state_q <= tpb_pkg::ENG_IDLE;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = (state_q == tpb_pkg::ENG_RUN) && (cnt_q == act_q[i*WW +: WW]);

    always_ff @(posedge clk) begin
      if (rst)         pulse_q[i] <= 1'b0;
      else if (start)  pulse_q[i] <= (width_flat[i*WW +: WW] != '0);
      else if (hit[i]) pulse_q[i] <= 1'b0;
    end
  end

  assign pulse    = pulse_q;
  assign cnt      = cnt_q;
  assign act_flat = act_q;
endmodule

// File: rtl/trig_pulse_bank.sv
module trig_pulse_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned WW  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              trig_in,
  input  logic [NCH*WW-1:0] dur_in,
  output logic [NCH-1:0]    pulse_out
);
  // Synchronised pins: [3]=trig, [2]=sclk, [1]=cs_n, [0]=mosi.
  logic [3:0]        pin_lvl;
  logic [1:0]        ctl_rise;
  logic [1:0]        ctl_fall;
  logic [NCH*WW-1:0] cfg_width;
  logic              cfg_commit;
  logic              eng_start;
  logic [WW-1:0]     eng_cnt;
  logic [NCH*WW-1:0] eng_act;

  tpb_sync #(.N(4), .RST_VAL(4'b0010)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({trig_in, spi_sclk, spi_cs_n, spi_mosi}),
    .q_out (pin_lvl)
  );

  // Edges of [1]=sclk, [0]=cs_n.
  tpb_edge #(.N(2), .RST_VAL(2'b01)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pin_lvl[2:1]),
    .rise (ctl_rise),
    .fall (ctl_fall)
  );

  tpb_spi_port #(.NCH(NCH), .WW(WW)) u_spi (
    .clk        (clk),
    .rst        (rst),
    .sclk_rise  (ctl_rise[1]),
    .sclk_fall  (ctl_fall[1]),
    .sel_lvl_n  (pin_lvl[1]),
    .sel_fall   (ctl_fall[0]),
    .sel_rise   (ctl_rise[0]),
    .mosi_lvl   (pin_lvl[0]),
    .dur_flat   (dur_in),
    .width_flat (cfg_width),
    .commit     (cfg_commit),
    .miso       (spi_miso)
  );

  tpb_pulse_engine #(.NCH(NCH), .WW(WW)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .trig_lvl   (pin_lvl[3]),
    .width_flat (cfg_width),
    .pulse      (pulse_out),
    .start      (eng_start),
    .cnt        (eng_cnt),
    .act_flat   (eng_act)
  );
endmodule

// File: rtl/tpb_checker.sv
module tpb_checker #(
  parameter int unsigned NCH = 8,
  parameter int unsigned WW  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic [NCH-1:0]    pulse_out,
  input logic              start,
  input logic [WW-1:0]     cnt,
  input logic [NCH*WW-1:0] act_w,
  input logic [NCH*WW-1:0] width,
  input logic              commit
);
  logic [NCH-1:0] zero_mask;

  always_comb begin
    for (int i = 0; i < NCH; i++) zero_mask[i] = (act_w[i*WW +: WW] == '0);
  end

  // R2
  width_only_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(width) |-> commit);

  // R4
  rise_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    ((pulse_out & ~$past(pulse_out)) != '0) |-> $past(start));

  // R6
  zero_width_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_out & zero_mask) == '0);

  // R11
  miso_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R5
    fall_on_match_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(pulse_out[i]) |-> ($past(cnt) == $past(act_w[i*WW +: WW])));
  end
endmodule

bind trig_pulse_bank tpb_checker #(.NCH(NCH), .WW(WW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .spi_cs_n  (spi_cs_n),
  .spi_miso  (spi_miso),
  .pulse_out (pulse_out),
  .start     (eng_start),
  .cnt       (eng_cnt),
  .act_w     (eng_act),
  .width     (cfg_width),
  .commit    (cfg_commit)
);

// File: tb/trig_pulse_bank_tb_top.sv
`timescale 1ns/1ps
module trig_pulse_bank_tb_top;
  localparam int NCH = 8;
  localparam int WW  = 12;
  localparam int TOT = NCH * WW;
  localparam int HALF_SCLK = 8;

  // {config frame (ch0 on top), durations (ch0 on top)}
  localparam logic [2*TOT-1:0] VEC [0:3] = '{
    {96'h001002003004005006007008, 96'hABC123456789FED000FFF555},
    {96'h0640000C80013E80007FF010, 96'h001112223334445556667778},
    {96'h800400200100080040020010, 96'hFFF000FFF000FFF000FFF000},
    {96'hFFF0FF00F000AAA555001002, 96'h123456789ABCDEF012345678}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  logic trig_in = 1'b0;
  logic [TOT-1:0] dur_in = '0;
  logic [NCH-1:0] pulse_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_pulse_bank #(.NCH(NCH), .WW(WW)) dut_i (
    .clk (clk), .rst (rst), .spi_sclk (spi_sclk), .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi), .spi_miso (spi_miso), .trig_in (trig_in),
    .dur_in (dur_in), .pulse_out (pulse_out)
  );

  // Pulse monitor
  logic clr = 1'b0;
  int cyc = 0;
  int rises [NCH];
  int hcnt [NCH];
  int last_len [NCH];
  int rise_t [NCH];
  logic [NCH-1:0] prev_p = '0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < NCH; i++) begin
      if (clr) begin
        rises[i] <= 0; hcnt[i] <= 0; last_len[i] <= -1; rise_t[i] <= -1;
      end else if (pulse_out[i] && !prev_p[i]) begin
        rises[i] <= rises[i] + 1; rise_t[i] <= cyc; hcnt[i] <= 1;
      end else if (pulse_out[i]) begin
        hcnt[i] <= hcnt[i] + 1;
      end else if (prev_p[i]) begin
        last_len[i] <= hcnt[i];
      end
    end
    prev_p <= pulse_out;
  end

  function automatic logic [WW-1:0] fld(input logic [TOT-1:0] w, input int i);
    return w[TOT-1-i*WW -: WW];
  endfunction

  function automatic logic [TOT-1:0] to_flat(input logic [TOT-1:0] w);
    logic [TOT-1:0] f;
    for (int i = 0; i < NCH; i++) f[i*WW +: WW] = w[TOT-1-i*WW -: WW];
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig_in = 1'b1;
    repeat (3) @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic xfer(input logic [TOT-1:0] tx, input int nbits, output logic [TOT-1:0] rx);
    rx = '0;
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (HALF_SCLK) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      spi_mosi = tx[TOT-1-b];
      repeat (HALF_SCLK) @(negedge clk);
      rx[TOT-1-b] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF_SCLK) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF_SCLK) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (HALF_SCLK) @(negedge clk);
  endtask

  // Start a run and check every channel against cfg.
  task automatic run_check(input logic [TOT-1:0] cfg, input string tag);
    int ref_t;
    clear_mon();
    pulse_trig();
    repeat (4300) @(negedge clk);
    ref_t = -1;
    for (int i = 0; i < NCH; i++) begin
      if (fld(cfg, i) == 0) begin
        // R6
        chk(rises[i] == 0, {"R6 zero width ", tag}, TOT'(rises[i]), '0);
      end else begin
        // R5 / R7
        chk(rises[i] == 1 && last_len[i] == int'(fld(cfg, i)),
            (fld(cfg, i) == 12'hFFF) ? {"R7 max width ", tag} : {"R5 width ", tag},
            TOT'(last_len[i]), TOT'(fld(cfg, i)));
        if (ref_t < 0) ref_t = rise_t[i];
        // R4
        chk(rise_t[i] == ref_t, {"R4 common rise ", tag}, TOT'(rise_t[i]), TOT'(ref_t));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [TOT-1:0] rx;
    logic [TOT-1:0] cfg;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(pulse_out == '0, "R1 pulses after reset", TOT'(pulse_out), '0);
    chk(spi_miso == 1'b0, "R1 miso after reset", TOT'(spi_miso), '0);
    run_check('0, "R1 reset widths");

    // Table walk: R2, R10, R4, R5, R6, R7
    for (int v = 0; v < 4; v++) begin
      cfg = VEC[v][2*TOT-1:TOT];
      dur_in = to_flat(VEC[v][TOT-1:0]);
      xfer(cfg, TOT, rx);
      // R10
      chk(rx == VEC[v][TOT-1:0], "R10 readout", rx, VEC[v][TOT-1:0]);
      // R11
      chk(spi_miso == 1'b0, "R11 miso idle", TOT'(spi_miso), '0);
      // R2 checked through the run
      run_check(cfg, "R2 table");
    end

    // R3: short and long frames leave widths unchanged
    xfer(96'hFFFFFFFFFFFFFFFFFFFFFFFF, 40, rx);
    run_check(VEC[3][2*TOT-1:TOT], "R3 short frame");
    xfer(96'h00F00F00F00F00F00F00F00F, 97, rx);
    run_check(VEC[3][2*TOT-1:TOT], "R3 long frame");

    // R8: restart during a run
    cfg = {12'd100, 12'd20, 72'd0};
    xfer(cfg, TOT, rx);
    clear_mon();
    @(negedge clk) trig_in = 1'b1;
    repeat (2) @(negedge clk);
    trig_in = 1'b0;
    repeat (38) @(negedge clk);
    trig_in = 1'b1;
    repeat (2) @(negedge clk);
    trig_in = 1'b0;
    repeat (4300) @(negedge clk);
    chk(rises[0] == 1 && last_len[0] == 140, "R8 restart extends", TOT'(last_len[0]), TOT'(140));
    chk(rises[1] == 2 && last_len[1] == 20, "R8 restart refires", TOT'(rises[1]), TOT'(2));

    // R9: commit during a run
    xfer({12'd3000, 84'd0}, TOT, rx);
    clear_mon();
    pulse_trig();
    xfer({12'd30, 84'd0}, TOT, rx);
    repeat (3000) @(negedge clk);
    chk(last_len[0] == 3000, "R9 run unaffected", TOT'(last_len[0]), TOT'(3000));
    run_check({12'd30, 84'd0}, "R9 next run");

    // R12: held trigger starts once
    xfer({12'd5, 12'd9, 72'd0}, TOT, rx);
    clear_mon();
    @(negedge clk) trig_in = 1'b1;
    repeat (5000) @(negedge clk);
    chk(rises[0] == 1 && rises[1] == 1, "R12 held trigger", TOT'(rises[0]), TOT'(1));
    trig_in = 1'b0;
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule